// File: doc/BRIEF.md
# Geometric Construction Console Controller

This block is the control unit between an operator console, a light-pen pulse input and a construction datapath that sweeps lines and circles. It holds the current drawing mode (line or circle). It also records whether the first point, the second point and the circle radius have been captured. From that state it derives the lamp outputs, the execute-ready indication, the write gate and the run enables that tell the datapath which point or radius registers are still tracking.

Every console button and the light-pen pulse are asynchronous inputs. Each one passes through a synchronizer and an edge detector, so that one press produces exactly one single-cycle event, however long the button is held. The horizontal and vertical coincidence flags come from the datapath's comparators. They are sampled on the block's own clock, either directly or through one register chosen by a parameter. The radius is captured in the cycle where both flags are true together.

Top module: `geo_console_ctrl`

## Requirements
- R1: After reset the block is in line mode (`circle_mode_o`=0). The point, radius and write-gate outputs are 0, `exec_ready_o` is 0 and `clear_ind_o` is 1.
- R2: A circle-button event sets `circle_mode_o` to 1 and a line-button event clears it to 0. No other input changes the mode.
- R3: A light-pen event sets `pt1_o`. A light-pen event that arrives while `pt1_o` is already 1 also sets `pt2_o`. `pt2_o` never rises while `pt1_o` is 0.
- R4: A button or pen input held high for any number of cycles yields one event only. A pen held for 20 cycles from the cleared state sets `pt1_o` and leaves `pt2_o` at 0.
- R5: The processor-reset button clears `pt1_o` and `pt2_o`. The point-one reset button clears only `pt1_o`, and the point-two reset button clears only `pt2_o`.
- R6: `rad_o` sets only when, in a single cycle, the block is in circle mode, `pt2_o` is 1, and both `hcoin_i` and `vcoin_i` are 1. It does not set in line mode, does not set without `pt2_o`, and does not set on one coincidence flag alone.
- R7: `rad_o` is cleared by the processor-reset button or the radius-reset button. The point-one and point-two reset buttons leave it unchanged.
- R8: `exec_ready_o` = `pt1_o` AND ((`pt2_o` AND line mode) OR (`rad_o` AND circle mode)).
- R9: `wgate_o` rises after the execute button is pressed and falls after it is released.
- R10: `clear_ind_o` is 1 exactly when `pt1_o`, `pt2_o` and `rad_o` are all 0.
- R11: When a set event and a clear event for the same flag arrive in the same cycle, the clear wins. Circle and line pressed together give line mode. Pen and point-one reset pressed together leave `pt1_o` at 0, and `pt2_o` still sets if `pt1_o` was 1 before.
- R12: `p1_run_o` = NOT `pt1_o`. `p2_run_o` = `pt1_o` AND NOT `pt2_o`. `rad_run_o` = circle mode AND `pt2_o` AND NOT `rad_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| btn_circle_i | input | 1 | Circle-mode button (asynchronous level) |
| btn_line_i | input | 1 | Line-mode button |
| btn_rst_all_i | input | 1 | Processor-reset button: clears both points and the radius |
| btn_rst_p1_i | input | 1 | Point-one reset button |
| btn_rst_p2_i | input | 1 | Point-two reset button |
| btn_rst_rad_i | input | 1 | Radius reset button |
| btn_exec_i | input | 1 | Execute button |
| pen_i | input | 1 | Light-pen pulse |
| hcoin_i | input | 1 | Horizontal coincidence flag from the datapath (synchronous) |
| vcoin_i | input | 1 | Vertical coincidence flag from the datapath (synchronous) |
| circle_mode_o | output | 1 | 1 = circle mode, 0 = line mode |
| pt1_o | output | 1 | First point captured |
| pt2_o | output | 1 | Second point captured |
| rad_o | output | 1 | Radius captured |
| exec_ready_o | output | 1 | Construction ready to be written |
| wgate_o | output | 1 | Write gate |
| clear_ind_o | output | 1 | Processor-reset indication (nothing captured) |
| p1_run_o | output | 1 | First-point registers still tracking |
| p2_run_o | output | 1 | Second-point registers tracking |
| rad_run_o | output | 1 | Radius register expanding |

## Verification
The hardest state to reach from the ports is a captured radius. It needs circle mode, both points captured in sequence, and a cycle in which both coincidence flags are high together. The stimulus builds this up by pressing pen twice in circle mode and then pulsing both flags in one cycle. Every combination of the three flags and the two modes is reached through sequences of presses, including selective point resets after the radius is held. The same-cycle set/clear conflicts are provoked by raising two raw buttons in the same cycle, so that their synchronized events coincide.

// File: rtl/geo_console_pkg.sv
package geo_console_pkg;

   // Event vector positions for the conditioned console inputs
   typedef enum int unsigned {
      EV_CIRCLE  = 0,
      EV_LINE    = 1,
      EV_RST_ALL = 2,
      EV_RST_P1  = 3,
      EV_RST_P2  = 4,
      EV_RST_RAD = 5,
      EV_EXEC    = 6,
      EV_PEN     = 7
   } ev_idx_e;

   localparam int unsigned NUM_EV = 8;

   typedef struct packed {
      logic circle;
      logic p1;
      logic p2;
      logic rad;
      logic wgate;
   } gcc_state_t;

endpackage

// File: rtl/gcc_in_cond.sv
module gcc_in_cond #(
   parameter int unsigned WIDTH  = 8,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic [WIDTH-1:0] raw_i,
   output logic [WIDTH-1:0] rise_o,
   output logic [WIDTH-1:0] fall_o
);

   localparam int unsigned MSB = STAGES - 1;

   if (STAGES < 2) begin : g_bad_stages
      $error("gcc_in_cond: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_bad_width
      $error("gcc_in_cond: WIDTH must be at least 1");
   end

   for (genvar i = 0; i < WIDTH; i++) begin : g_bit
      logic [STAGES-1:0] sh_q;
      logic              prev_q;

      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            sh_q   <= '0;
            prev_q <= 1'b0;
         end else begin
            sh_q   <= {sh_q[MSB-1:0], raw_i[i]};
            prev_q <= sh_q[MSB];
         end
      end

      assign rise_o[i] =  sh_q[MSB] & ~prev_q;
      assign fall_o[i] = ~sh_q[MSB] &  prev_q;
   end

endmodule

// File: rtl/gcc_flags.sv
module gcc_flags
   import geo_console_pkg::*;
(
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic [NUM_EV-1:0] rise_i,
   input  logic [NUM_EV-1:0] fall_i,
   input  logic              hco_i,
   input  logic              vco_i,
   output gcc_state_t        st_o
);

   gcc_state_t st_q;
   logic       clr_p1, clr_p2, clr_rad;
   logic       set_p1, set_p2, set_rad;

   // Clears take priority over sets
   assign clr_p1  = rise_i[EV_RST_ALL] | rise_i[EV_RST_P1];
   assign clr_p2  = rise_i[EV_RST_ALL] | rise_i[EV_RST_P2];
   assign clr_rad = rise_i[EV_RST_ALL] | rise_i[EV_RST_RAD];
   assign set_p1  = rise_i[EV_PEN];
   assign set_p2  = rise_i[EV_PEN] & st_q.p1;
   assign set_rad = st_q.circle & st_q.p2 & hco_i & vco_i;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         st_q <= '0;
      end else begin
         if (rise_i[EV_LINE])        st_q.circle <= 1'b0;
         else if (rise_i[EV_CIRCLE]) st_q.circle <= 1'b1;

         if (clr_p1)      st_q.p1 <= 1'b0;
         else if (set_p1) st_q.p1 <= 1'b1;

         if (clr_p2)      st_q.p2 <= 1'b0;
         else if (set_p2) st_q.p2 <= 1'b1;

         if (clr_rad)      st_q.rad <= 1'b0;
         else if (set_rad) st_q.rad <= 1'b1;

         if (fall_i[EV_EXEC])      st_q.wgate <= 1'b0;
         else if (rise_i[EV_EXEC]) st_q.wgate <= 1'b1;
      end
   end

   assign st_o = st_q;

endmodule

// File: rtl/gcc_indic.sv
module gcc_indic
   import geo_console_pkg::*;
(
   input  gcc_state_t st_i,
   output logic       exec_ready_o,
   output logic       clear_ind_o,
   output logic       p1_run_o,
   output logic       p2_run_o,
   output logic       rad_run_o
);

   logic line_ok, circ_ok;

   always_comb begin
      line_ok      = st_i.p1 & st_i.p2  & ~st_i.circle;
      circ_ok      = st_i.p1 & st_i.rad &  st_i.circle;
      exec_ready_o = line_ok | circ_ok;
      clear_ind_o  = ~(st_i.p1 | st_i.p2 | st_i.rad);
      p1_run_o     = ~st_i.p1;
      p2_run_o     =  st_i.p1 & ~st_i.p2;
      rad_run_o    =  st_i.circle & st_i.p2 & ~st_i.rad;
   end

endmodule

// File: rtl/geo_console_ctrl.sv
module geo_console_ctrl
   import geo_console_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          COIN_REG    = 1'b0
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic btn_circle_i,
   input  logic btn_line_i,
   input  logic btn_rst_all_i,
   input  logic btn_rst_p1_i,
   input  logic btn_rst_p2_i,
   input  logic btn_rst_rad_i,
   input  logic btn_exec_i,
   input  logic pen_i,
   input  logic hcoin_i,
   input  logic vcoin_i,
   output logic circle_mode_o,
   output logic pt1_o,
   output logic pt2_o,
   output logic rad_o,
   output logic exec_ready_o,
   output logic wgate_o,
   output logic clear_ind_o,
   output logic p1_run_o,
   output logic p2_run_o,
   output logic rad_run_o
);

   logic [NUM_EV-1:0] raw;
   logic [NUM_EV-1:0] ev_rise;
   logic [NUM_EV-1:0] ev_fall;
   logic              hco_s, vco_s;
   gcc_state_t        st;

   always_comb begin
      raw             = '0;
      raw[EV_CIRCLE]  = btn_circle_i;
      raw[EV_LINE]    = btn_line_i;
      raw[EV_RST_ALL] = btn_rst_all_i;
      raw[EV_RST_P1]  = btn_rst_p1_i;
      raw[EV_RST_P2]  = btn_rst_p2_i;
      raw[EV_RST_RAD] = btn_rst_rad_i;
      raw[EV_EXEC]    = btn_exec_i;
      raw[EV_PEN]     = pen_i;
   end

   gcc_in_cond #(
      .WIDTH  (NUM_EV),
      .STAGES (SYNC_STAGES)
   ) u_cond (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .raw_i  (raw),
      .rise_o (ev_rise),
      .fall_o (ev_fall)
   );

   if (COIN_REG) begin : g_coin_reg
      logic hq, vq;
      always_ff @(posedge clk_i or negedge rst_ni) begin
         if (!rst_ni) begin
            hq <= 1'b0;
            vq <= 1'b0;
         end else begin
            hq <= hcoin_i;
            vq <= vcoin_i;
         end
      end
      assign hco_s = hq;
      assign vco_s = vq;
   end else begin : g_coin_direct
      assign hco_s = hcoin_i;
      assign vco_s = vcoin_i;
   end

   gcc_flags u_flags (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .rise_i (ev_rise),
      .fall_i (ev_fall),
      .hco_i  (hco_s),
      .vco_i  (vco_s),
      .st_o   (st)
   );

   gcc_indic u_indic (
      .st_i         (st),
      .exec_ready_o (exec_ready_o),
      .clear_ind_o  (clear_ind_o),
      .p1_run_o     (p1_run_o),
      .p2_run_o     (p2_run_o),
      .rad_run_o    (rad_run_o)
   );

   assign circle_mode_o = st.circle;
   assign pt1_o         = st.p1;
   assign pt2_o         = st.p2;
   assign rad_o         = st.rad;
   assign wgate_o       = st.wgate;

endmodule

// File: rtl/gcc_checker.sv
module gcc_checker
   import geo_console_pkg::*;
(
   input logic              clk_i,
   input logic              rst_ni,
   input logic [NUM_EV-1:0] ev_rise,
   input logic [NUM_EV-1:0] ev_fall,
   input logic              hco_s,
   input logic              vco_s,
   input logic              circle_mode_o,
   input logic              pt1_o,
   input logic              pt2_o,
   input logic              rad_o,
   input logic              exec_ready_o,
   input logic              wgate_o,
   input logic              clear_ind_o
);

   // R2
   mode_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !(ev_rise[EV_CIRCLE] || ev_rise[EV_LINE]) |=> $stable(circle_mode_o));

   // R3
   p2_after_p1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(pt2_o) |-> $past(pt1_o));

   // R4
   pen_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_rise[EV_PEN] |=> !ev_rise[EV_PEN]);

   // R6
   rad_cause_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(rad_o) |-> $past(circle_mode_o && pt2_o && hco_s && vco_s));

   // R7
   rad_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev_rise[EV_RST_ALL] || ev_rise[EV_RST_RAD]) |=> !rad_o);

   // R9
   wgate_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      $rose(wgate_o) |-> $past(ev_rise[EV_EXEC]));

   // R9
   wgate_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_fall[EV_EXEC] |=> !wgate_o);

   // R11
   all_clear_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_rise[EV_RST_ALL] |=> (!pt1_o && !pt2_o && !rad_o && clear_ind_o));

   // R11
   line_wins_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ev_rise[EV_LINE] |=> !circle_mode_o);

   // R8
   ready_needs_p1_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      exec_ready_o |-> pt1_o);

endmodule

bind geo_console_ctrl gcc_checker u_chk (
   .clk_i         (clk_i),
   .rst_ni        (rst_ni),
   .ev_rise       (ev_rise),
   .ev_fall       (ev_fall),
   .hco_s         (hco_s),
   .vco_s         (vco_s),
   .circle_mode_o (circle_mode_o),
   .pt1_o         (pt1_o),
   .pt2_o         (pt2_o),
   .rad_o         (rad_o),
   .exec_ready_o  (exec_ready_o),
   .wgate_o       (wgate_o),
   .clear_ind_o   (clear_ind_o)
);

// File: tb/sim_geo_console_ctrl.sv
`timescale 1ns/1ps
module sim_geo_console_ctrl;

   localparam int B_CIRC = 0, B_LINE = 1, B_RALL = 2, B_RP1 = 3,
                  B_RP2 = 4, B_RRAD = 5, B_EXEC = 6, B_PEN = 7;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] btn = '0;
   logic       hco = 1'b0, vco = 1'b0;
   logic       circ, p1, p2, rad, rdy, wg, clr, r1, r2, rr;
   int         checks = 0, errors = 0;
   bit         done = 1'b0;

   always #2 clk = ~clk;

   geo_console_ctrl u0 (
      .clk_i(clk), .rst_ni(rst_n),
      .btn_circle_i(btn[B_CIRC]), .btn_line_i(btn[B_LINE]),
      .btn_rst_all_i(btn[B_RALL]), .btn_rst_p1_i(btn[B_RP1]),
      .btn_rst_p2_i(btn[B_RP2]), .btn_rst_rad_i(btn[B_RRAD]),
      .btn_exec_i(btn[B_EXEC]), .pen_i(btn[B_PEN]),
      .hcoin_i(hco), .vcoin_i(vco),
      .circle_mode_o(circ), .pt1_o(p1), .pt2_o(p2), .rad_o(rad),
      .exec_ready_o(rdy), .wgate_o(wg), .clear_ind_o(clr),
      .p1_run_o(r1), .p2_run_o(r2), .rad_run_o(rr)
   );

   task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   // press a set of buttons together, hold, release
   task automatic press(input logic [7:0] m, input int hold = 5);
      @(negedge clk); btn = m;
      repeat (hold) @(negedge clk);
      btn = '0;
      repeat (5) @(negedge clk);
   endtask

   task automatic coin(input logic h, input logic v);
      @(negedge clk); hco = h; vco = v;
      @(negedge clk); hco = 1'b0; vco = 1'b0;
      repeat (2) @(negedge clk);
   endtask

   function automatic logic [9:0] expv(input logic c, input logic a,
                                       input logic b, input logic r);
      logic e, z;
      e = a & ((b & ~c) | (r & c));
      z = ~(a | b | r);
      return {c, a, b, r, e, z, ~a, a & ~b, c & b & ~r, 1'b0};
   endfunction

   function automatic logic [9:0] outv();
      return {circ, p1, p2, rad, rdy, clr, r1, r2, rr, wg};
   endfunction

   task automatic reach(input logic a, input logic b, input logic r, input logic c);
      press(8'h1 << B_RALL);
      press(8'h1 << B_CIRC);
      if (r || b) begin press(8'h1 << B_PEN); press(8'h1 << B_PEN); end
      else if (a) press(8'h1 << B_PEN);
      if (r) coin(1'b1, 1'b1);
      if ((r || b) && !b) press(8'h1 << B_RP2);
      if ((r || b || a) && !a) press(8'h1 << B_RP1);
      if (!c) press(8'h1 << B_LINE);
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      if (!done) begin
         errors++;
         checks++;
         $display("FAIL watchdog expired");
         $display("CHECKS %0d ERRORS %0d", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 reset outputs", outv(), expv(0, 0, 0, 0));

      // R2 mode set/clear
      press(8'h1 << B_CIRC);
      chk("R2 circle button", circ, 1);
      press(8'h1 << B_RALL);
      chk("R2 mode kept by reset button", circ, 1);
      press(8'h1 << B_LINE);
      chk("R2 line button", circ, 0);

      // R4 long pen hold gives one event
      press(8'h1 << B_PEN, 20);
      chk("R4 held pen sets only pt1", {p1, p2}, 2'b10);
      // R3 second pen sets pt2
      press(8'h1 << B_PEN);
      chk("R3 second pen sets pt2", {p1, p2}, 2'b11);
      // R5 selective resets
      press(8'h1 << B_RP1);
      chk("R5 point-one reset", {p1, p2}, 2'b01);
      press(8'h1 << B_PEN);
      press(8'h1 << B_RP2);
      chk("R5 point-two reset", {p1, p2}, 2'b10);

      // R6 negatives: line mode with both points, coincidence
      press(8'h1 << B_PEN);
      coin(1'b1, 1'b1);
      chk("R6 no radius in line mode", rad, 0);
      press(8'h1 << B_CIRC);
      coin(1'b1, 1'b0);
      chk("R6 no radius on horizontal only", rad, 0);
      coin(1'b0, 1'b1);
      chk("R6 no radius on vertical only", rad, 0);
      chk("R12 radius expanding", rr, 1);
      coin(1'b1, 1'b1);
      chk("R6 radius captured", rad, 1);
      chk("R8 ready in circle", rdy, 1);
      // R7 point resets keep radius
      press(8'h1 << B_RP1);
      press(8'h1 << B_RP2);
      chk("R7 radius kept by point resets", {p1, p2, rad}, 3'b001);
      chk("R10 indication off with radius", clr, 0);
      press(8'h1 << B_RRAD);
      chk("R7 radius reset", rad, 0);
      chk("R10 indication on", clr, 1);
      // R6 without pt2 in circle mode
      press(8'h1 << B_PEN);
      coin(1'b1, 1'b1);
      chk("R6 no radius without pt2", rad, 0);
      press(8'h1 << B_PEN);
      coin(1'b1, 1'b1);
      press(8'h1 << B_RALL);
      chk("R7 processor reset clears all", {p1, p2, rad}, 3'b000);

      // R9 write gate
      @(negedge clk); btn = 8'h1 << B_EXEC;
      repeat (5) @(negedge clk);
      chk("R9 write gate while held", wg, 1);
      btn = '0;
      repeat (5) @(negedge clk);
      chk("R9 write gate after release", wg, 0);

      // R11 clear priority
      press((8'h1 << B_CIRC) | (8'h1 << B_LINE));
      chk("R11 line wins over circle", circ, 0);
      press(8'h1 << B_PEN);
      press((8'h1 << B_PEN) | (8'h1 << B_RP1));
      chk("R11 pen with point-one reset", {p1, p2}, 2'b01);
      press(8'h1 << B_RALL);
      press((8'h1 << B_PEN) | (8'h1 << B_RP1));
      chk("R11 pen with reset from empty", {p1, p2}, 2'b00);

      // R8 R10 R12 sweep over all flag states and modes
      for (int s = 0; s < 16; s++) begin
         logic a, b, r, c;
         {c, r, b, a} = s[3:0];
         reach(a, b, r, c);
         chk($sformatf("R8 R10 R12 sweep state %0d", s), outv(), expv(c, a, b, r));
      end

      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
   end

endmodule